// File: doc/BRIEF.md
# Modulo Address Generator for Dual Data-Memory Transfers

This unit computes post-transfer address values for a DSP-style core that moves data over two data-memory ports, X and Y, in the same cycle. For each channel it takes the address register's current value, the channel's index register and a two-bit update code. It returns the updated address register value and the address to place on that channel's 16-bit data-memory bus. A bounds register holds a modulo end address and a modulo start address. Each channel has its own enable. When a channel is enabled and an updating transfer begins at the end address, the address register folds back to the start address instead of advancing. This gives circular buffers of up to 64 KB.

Transfers arrive as a valid-qualified stream per channel with no ready signal. Every beat is accepted, so there is no back-pressure. The result beat appears exactly one clock later, qualified by the channel's output valid, and the consumer must take it in that cycle. The result registers keep their values while no beat arrives. Bounds and enables are written through plain control pins. A write takes effect for transfers presented from the next clock onward.

Top module: `modaddr_gen`

## Requirements
- R1: A synchronous reset clears both output valids, both channel enables and both bounds fields. After reset, an updating transfer at address 0 does not wrap.
- R2: Writing the bounds word places bits 31:16 in the end field and bits 15:0 in the start field. A transfer presented in the same cycle as the write still uses the old bounds.
- R3: Update code 01 adds 2 and code 10 adds the index register. The result appears one cycle after the input beat, with the output valid high exactly when the input valid was high one cycle earlier.
- R4: The bus address output equals bits 15:1 of the pre-update address with bit 0 forced to 0.
- R5: On a wrap, bits 15:1 of the result come from the start field. Bits 31:16 and bit 0 of the result keep their pre-update values.
- R6: The end-address compare uses only bits 15:1. Bit 0 of the address and bit 0 of the end field do not affect whether a wrap happens.
- R7: Update code 00 leaves the address unchanged and never wraps, even when the address equals the end address.
- R8: A channel whose enable is 0 never wraps. The enable bits are written together through a separate write strobe.
- R9: The X and Y channels are evaluated independently, and both may wrap in the same cycle.
- R10: Update code 11 behaves as code 00: the address is unchanged and no wrap occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bnd_we | input | 1 | Bounds register write strobe |
| bnd_wdata | input | 32 | Bounds word: end in 31:16, start in 15:0 |
| ena_we | input | 1 | Channel enable write strobe |
| ena_x_d | input | 1 | New modulo enable for X |
| ena_y_d | input | 1 | New modulo enable for Y |
| x_in_vld | input | 1 | X transfer beat valid |
| x_addr | input | 32 | X address register value before update |
| x_idx | input | 32 | X index register |
| x_op | input | 2 | X update code (00 none, 01 +2, 10 +index, 11 none) |
| y_in_vld | input | 1 | Y transfer beat valid |
| y_addr | input | 32 | Y address register value before update |
| y_idx | input | 32 | Y index register |
| y_op | input | 2 | Y update code |
| x_out_vld | output | 1 | X result valid |
| x_next | output | 32 | X updated address register value |
| x_bus | output | 16 | X data-memory bus address |
| y_out_vld | output | 1 | Y result valid |
| y_next | output | 32 | Y updated address register value |
| y_bus | output | 16 | Y data-memory bus address |

## Verification
Two events can land in one cycle: a bounds write and a transfer sitting exactly on the old end address. The bench presents both in the same cycle. It expects the fold to use the old start address. In the following cycle it expects a transfer at the new end address to fold to the new start. Random stimulus then mixes bounds writes, enable writes and end-address hits on both channels at once. Every result is compared against a behavioural model whose bounds only change after the edge.

// File: rtl/modaddr_pkg.sv
package modaddr_pkg;
  typedef enum logic [1:0] {
    UPD_NONE  = 2'b00,
    UPD_INC2  = 2'b01,
    UPD_INDEX = 2'b10,
    UPD_HOLD  = 2'b11
  } upd_e;
endpackage

// File: rtl/modaddr_bounds.sv
module modaddr_bounds #(
  parameter int AW = 32,
  parameter int MW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bnd_we,
  input  logic [AW-1:0] bnd_wdata,
  input  logic          ena_we,
  input  logic          ena_x_d,
  input  logic          ena_y_d,
  output logic [MW-1:0] mod_end,
  output logic [MW-1:0] mod_start,
  output logic          en_x,
  output logic          en_y
);
  // end field sits in the upper field of the bounds word
  always_ff @(posedge clk) begin
    if (rst) begin
      mod_end   <= '0;
      mod_start <= '0;
    end else if (bnd_we) begin
      mod_end   <= bnd_wdata[2*MW-1:MW];
      mod_start <= bnd_wdata[MW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_x <= 1'b0;
      en_y <= 1'b0;
    end else if (ena_we) begin
      en_x <= ena_x_d;
      en_y <= ena_y_d;
    end
  end
endmodule

// File: rtl/modaddr_chan.sv
module modaddr_chan
  import modaddr_pkg::*;
#(
  parameter int AW   = 32,
  parameter int MW   = 16,
  parameter int STEP = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] idx,
  input  upd_e          op,
  input  logic          en,
  input  logic [MW-1:0] mod_end,
  input  logic [MW-1:0] mod_start,
  output logic          out_vld,
  output logic [AW-1:0] next_addr,
  output logic [MW-1:0] bus_addr
);
  logic [AW-1:0] stepped;
  logic [AW-1:0] folded;
  logic [AW-1:0] result;
  logic          updating;
  logic          hit;

  always_comb begin
    unique case (op)
      UPD_INC2:  stepped = addr + AW'(STEP);
      UPD_INDEX: stepped = addr + idx;
      default:   stepped = addr;
    endcase
  end

  assign updating = (op == UPD_INC2) || (op == UPD_INDEX);
  // bit 0 takes no part in the compare
  assign hit      = en && updating && (addr[MW-1:1] == mod_end[MW-1:1]);

  always_comb begin
    folded         = addr;
    folded[MW-1:1] = mod_start[MW-1:1];
  end

  assign result = hit ? folded : stepped;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld   <= 1'b0;
      next_addr <= '0;
      bus_addr  <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        next_addr <= result;
        bus_addr  <= {addr[MW-1:1], 1'b0};
      end
    end
  end
endmodule

// File: rtl/modaddr_gen.sv
module modaddr_gen
  import modaddr_pkg::*;
#(
  parameter int AW   = 32,
  parameter int MW   = 16,
  parameter int STEP = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bnd_we,
  input  logic [AW-1:0] bnd_wdata,
  input  logic          ena_we,
  input  logic          ena_x_d,
  input  logic          ena_y_d,
  input  logic          x_in_vld,
  input  logic [AW-1:0] x_addr,
  input  logic [AW-1:0] x_idx,
  input  logic [1:0]    x_op,
  input  logic          y_in_vld,
  input  logic [AW-1:0] y_addr,
  input  logic [AW-1:0] y_idx,
  input  logic [1:0]    y_op,
  output logic          x_out_vld,
  output logic [AW-1:0] x_next,
  output logic [MW-1:0] x_bus,
  output logic          y_out_vld,
  output logic [AW-1:0] y_next,
  output logic [MW-1:0] y_bus
);
  localparam int NCH = 2;

  logic [MW-1:0] mod_end;
  logic [MW-1:0] mod_start;
  logic          en_x;
  logic          en_y;

  logic          c_vld  [NCH];
  logic [AW-1:0] c_addr [NCH];
  logic [AW-1:0] c_idx  [NCH];
  upd_e          c_op   [NCH];
  logic          c_en   [NCH];
  logic          c_ovld [NCH];
  logic [AW-1:0] c_next [NCH];
  logic [MW-1:0] c_bus  [NCH];

  modaddr_bounds #(.AW(AW), .MW(MW)) u_bounds (
    .clk       (clk),
    .rst       (rst),
    .bnd_we    (bnd_we),
    .bnd_wdata (bnd_wdata),
    .ena_we    (ena_we),
    .ena_x_d   (ena_x_d),
    .ena_y_d   (ena_y_d),
    .mod_end   (mod_end),
    .mod_start (mod_start),
    .en_x      (en_x),
    .en_y      (en_y)
  );

  assign c_vld[0]  = x_in_vld;
  assign c_addr[0] = x_addr;
  assign c_idx[0]  = x_idx;
  assign c_op[0]   = upd_e'(x_op);
  assign c_en[0]   = en_x;
  assign c_vld[1]  = y_in_vld;
  assign c_addr[1] = y_addr;
  assign c_idx[1]  = y_idx;
  assign c_op[1]   = upd_e'(y_op);
  assign c_en[1]   = en_y;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    modaddr_chan #(.AW(AW), .MW(MW), .STEP(STEP)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .in_vld    (c_vld[c]),
      .addr      (c_addr[c]),
      .idx       (c_idx[c]),
      .op        (c_op[c]),
      .en        (c_en[c]),
      .mod_end   (mod_end),
      .mod_start (mod_start),
      .out_vld   (c_ovld[c]),
      .next_addr (c_next[c]),
      .bus_addr  (c_bus[c])
    );
  end

  assign x_out_vld = c_ovld[0];
  assign x_next    = c_next[0];
  assign x_bus     = c_bus[0];
  assign y_out_vld = c_ovld[1];
  assign y_next    = c_next[1];
  assign y_bus     = c_bus[1];
endmodule

// File: rtl/modaddr_gen_chk.sv
module modaddr_gen_chk #(
  parameter int AW = 32,
  parameter int MW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          x_in_vld,
  input logic [AW-1:0] x_addr,
  input logic [1:0]    x_op,
  input logic          y_in_vld,
  input logic [AW-1:0] y_addr,
  input logic [1:0]    y_op,
  input logic          x_out_vld,
  input logic [AW-1:0] x_next,
  input logic [MW-1:0] x_bus,
  input logic          y_out_vld,
  input logic [AW-1:0] y_next,
  input logic [MW-1:0] y_bus,
  input logic [MW-1:0] me,
  input logic [MW-1:0] ms,
  input logic          en_x,
  input logic          en_y
);
  AST_X_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    x_in_vld |=> x_out_vld); // R3
  AST_X_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !x_in_vld |=> !x_out_vld); // R3
  AST_Y_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    y_in_vld |=> y_out_vld); // R3
  AST_X_BUS_PREUPD: assert property (@(posedge clk) disable iff (rst)
    x_in_vld |=> x_bus == {$past(x_addr[MW-1:1]), 1'b0}); // R4
  AST_Y_BUS_PREUPD: assert property (@(posedge clk) disable iff (rst)
    y_in_vld |=> y_bus == {$past(y_addr[MW-1:1]), 1'b0}); // R4
  AST_X_NOUPD_KEEP: assert property (@(posedge clk) disable iff (rst)
    x_in_vld && (x_op == 2'b00) |=> x_next == $past(x_addr)); // R7
  AST_X_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
    x_in_vld && (x_op == 2'b11) |=> x_next == $past(x_addr)); // R10
  AST_X_WRAP_FOLD: assert property (@(posedge clk) disable iff (rst)
    x_in_vld && en_x && (x_op == 2'b01 || x_op == 2'b10) && (x_addr[MW-1:1] == me[MW-1:1])
    |=> x_next == {$past(x_addr[AW-1:MW]), $past(ms[MW-1:1]), $past(x_addr[0])}); // R5
  AST_Y_WRAP_FOLD: assert property (@(posedge clk) disable iff (rst)
    y_in_vld && en_y && (y_op == 2'b01 || y_op == 2'b10) && (y_addr[MW-1:1] == me[MW-1:1])
    |=> y_next == {$past(y_addr[AW-1:MW]), $past(ms[MW-1:1]), $past(y_addr[0])}); // R5
  AST_X_OFF_PLAIN: assert property (@(posedge clk) disable iff (rst)
    x_in_vld && !en_x && (x_op == 2'b01) |=> x_next == AW'($past(x_addr) + AW'(2))); // R8
  AST_Y_OFF_PLAIN: assert property (@(posedge clk) disable iff (rst)
    y_in_vld && !en_y && (y_op == 2'b01) |=> y_next == AW'($past(y_addr) + AW'(2))); // R8
endmodule

bind modaddr_gen modaddr_gen_chk #(.AW(AW), .MW(MW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .x_in_vld  (x_in_vld),
  .x_addr    (x_addr),
  .x_op      (x_op),
  .y_in_vld  (y_in_vld),
  .y_addr    (y_addr),
  .y_op      (y_op),
  .x_out_vld (x_out_vld),
  .x_next    (x_next),
  .x_bus     (x_bus),
  .y_out_vld (y_out_vld),
  .y_next    (y_next),
  .y_bus     (y_bus),
  .me        (mod_end),
  .ms        (mod_start),
  .en_x      (en_x),
  .en_y      (en_y)
);

// File: tb/modaddr_gen_bench.sv
module modaddr_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bnd_we = 0;
  logic [31:0] bnd_wdata = 0;
  logic        ena_we = 0, ena_x_d = 0, ena_y_d = 0;
  logic        x_in_vld = 0, y_in_vld = 0;
  logic [31:0] x_addr = 0, x_idx = 0, y_addr = 0, y_idx = 0;
  logic [1:0]  x_op = 0, y_op = 0;
  logic        x_out_vld, y_out_vld;
  logic [31:0] x_next, y_next;
  logic [15:0] x_bus, y_bus;

  always #10 clk = ~clk;

  modaddr_gen u_modaddr_gen (
    .clk(clk), .rst(rst), .bnd_we(bnd_we), .bnd_wdata(bnd_wdata),
    .ena_we(ena_we), .ena_x_d(ena_x_d), .ena_y_d(ena_y_d),
    .x_in_vld(x_in_vld), .x_addr(x_addr), .x_idx(x_idx), .x_op(x_op),
    .y_in_vld(y_in_vld), .y_addr(y_addr), .y_idx(y_idx), .y_op(y_op),
    .x_out_vld(x_out_vld), .x_next(x_next), .x_bus(x_bus),
    .y_out_vld(y_out_vld), .y_next(y_next), .y_bus(y_bus)
  );

  int checks = 0;
  int errors = 0;

  // reference state: bounds and enables as seen by the transfers
  logic [15:0] m_end = 0, m_start = 0;
  logic        m_ex = 0, m_ey = 0;
  // expectation pending for the next sample point
  logic        p_have = 0;
  logic        p_xv, p_yv;
  logic [31:0] p_xn, p_yn;
  logic [15:0] p_xb, p_yb;
  string       p_tag;

  function automatic logic [31:0] ref_next(logic [31:0] a, logic [31:0] i,
                                           logic [1:0] op, logic en);
    logic [31:0] r;
    logic        moving;
    moving = (op == 2'd1) || (op == 2'd2);
    r = (op == 2'd1) ? a + 32'd2 : (op == 2'd2) ? a + i : a;
    if (en && moving && (a[15:1] == m_end[15:1]))
      r = {a[31:16], m_start[15:1], a[0]};
    return r;
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic judge();
    cmp(p_tag, "x_out_vld", {31'd0, x_out_vld}, {31'd0, p_xv});
    cmp(p_tag, "y_out_vld", {31'd0, y_out_vld}, {31'd0, p_yv});
    if (p_xv) begin
      cmp(p_tag, "x_next", x_next, p_xn);
      cmp(p_tag, "x_bus", {16'd0, x_bus}, {16'd0, p_xb});
    end
    if (p_yv) begin
      cmp(p_tag, "y_next", y_next, p_yn);
      cmp(p_tag, "y_bus", {16'd0, y_bus}, {16'd0, p_yb});
    end
  endtask

  // one cycle: judge the previous beat, then present a new one
  task automatic step(string tag,
                      logic xv, logic [31:0] xa, logic [31:0] xi, logic [1:0] xo,
                      logic yv, logic [31:0] ya, logic [31:0] yi, logic [1:0] yo,
                      logic bwe, logic [31:0] bd,
                      logic ewe, logic ex, logic ey);
    @(negedge clk);
    if (p_have) judge();
    x_in_vld = xv; x_addr = xa; x_idx = xi; x_op = xo;
    y_in_vld = yv; y_addr = ya; y_idx = yi; y_op = yo;
    bnd_we = bwe; bnd_wdata = bd;
    ena_we = ewe; ena_x_d = ex; ena_y_d = ey;
    p_have = 1; p_tag = tag;
    p_xv = xv; p_yv = yv;
    p_xn = ref_next(xa, xi, xo, m_ex);
    p_yn = ref_next(ya, yi, yo, m_ey);
    p_xb = {xa[15:1], 1'b0};
    p_yb = {ya[15:1], 1'b0};
    if (bwe) begin m_end = bd[31:16]; m_start = bd[15:0]; end
    if (ewe) begin m_ex = ex; m_ey = ey; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs quiet in reset
    cmp("R1", "x_out_vld in reset", {31'd0, x_out_vld}, 32'd0);
    cmp("R1", "y_out_vld in reset", {31'd0, y_out_vld}, 32'd0);
    rst = 0;
    // R1: cleared enables and bounds, addr 0 matches end 0 but no wrap
    step("R1", 1, 32'h0, 0, 2'd1, 1, 32'h0, 0, 2'd1, 0, 0, 0, 0, 0);
    // R2: load bounds end=0x0040 start=0x0010, enable both
    step("R3", 1, 32'h100, 32'h20, 2'd2, 0, 0, 0, 0, 1, 32'h0040_0010, 1, 1, 1);
    step("R5", 1, 32'h1234_0040, 0, 2'd1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R5", 1, 32'hABCD_0041, 32'h8, 2'd2, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R2: write new bounds in the same cycle as a hit on the old end
    step("R2", 1, 32'h0000_0040, 0, 2'd1, 0, 0, 0, 0, 1, 32'h0081_0030, 0, 0, 0);
    step("R2", 1, 32'h0000_0080, 0, 2'd1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R6: end field bit0 set, address bit0 set: still a hit
    step("R6", 1, 32'h0000_0081, 0, 2'd1, 1, 32'h0000_0080, 0, 2'd1, 0, 0, 0, 0, 0);
    // R7 and R10: non-updating codes at the end address
    step("R7", 1, 32'h0000_0080, 0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R10", 1, 32'h0000_0081, 0, 2'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R4: bus address from pre-update value
    step("R4", 1, 32'h5555_7777, 32'h4, 2'd2, 1, 32'h0000_FFFF, 0, 2'd1, 0, 0, 0, 0, 0);
    // R8: disable X only, both at the end address
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1);
    step("R8", 1, 32'h0000_0080, 0, 2'd1, 1, 32'h0000_0080, 0, 2'd1, 0, 0, 0, 0, 0);
    // R9: both enabled, both wrap together with different codes
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1);
    step("R9", 1, 32'h7000_0080, 0, 2'd1, 1, 32'h0001_0081, 32'h10, 2'd2, 0, 0, 0, 0, 0);
    step("R3", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // mixed traffic with frequent end-address hits and control writes
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] xa, ya, bd;
      xa = $urandom; ya = $urandom; bd = $urandom;
      if ($urandom_range(1, 0) == 1) xa[15:1] = m_end[15:1];
      if ($urandom_range(1, 0) == 1) ya[15:1] = m_end[15:1];
      step("R9", 1'($urandom), xa, $urandom, 2'($urandom),
           1'($urandom), ya, $urandom, 2'($urandom),
           ($urandom_range(7, 0) == 0), bd,
           ($urandom_range(7, 0) == 0), 1'($urandom), 1'($urandom));
    end
    step("R3", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    judge();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule